// File: doc/BRIEF.md
# Wide-to-Narrow Bus Access Sequencer

This block sits between a 64-bit processor core and a 16-bit external memory bus. The bus runs at half the core clock rate. The core hands the sequencer one access at a time: an instruction fetch, or a load or store of a byte, half-word, word or double-word. The sequencer breaks the access into 16-bit bus beats at ascending half-word addresses, low half first. For stores it scatters the data over the byte lanes. For loads it gathers the returned halves into a right-justified result. Each beat holds the bus for two core cycles, so every access costs a fixed number of cycles that depends only on its size.

The core side uses a valid/ready request channel. `req_ready` is high only while the sequencer is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A request presented while `req_ready` is low is neither taken nor remembered, so the core must hold it until it is taken. The response cannot be back-pressured. A single-cycle `done` pulse marks the cycle in which `rd_data` and `acc_cycles` are valid, and the core must take them then. `rd_data` keeps its value until the next request is taken. The bus side is a plain strobe interface with no wait states.

Top module: `bus_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no access is in progress and no `done` pulse is showing. A request offered while `req_ready` is 0 is ignored and causes no bus activity.
- R2: The size code is 0 for byte, 1 for half-word, 2 for word and 3 for double-word. These take 1, 1, 2 and 4 bus beats respectively.
- R3: Each beat keeps `bus_stb` high for two consecutive core cycles. `bus_addr`, `bus_sel`, `bus_we` and `bus_wdata` are held constant for both cycles, and read data is sampled in the second cycle.
- R4: For beat k of an access, `bus_addr` is the request address shifted right by one, plus k. For a store, beat k carries bits [16k+15:16k] of `req_wdata`, so the low half goes first.
- R5: `bus_sel` bit 0 enables the even byte and bit 1 enables the odd byte. A byte access sets only the bit chosen by address bit 0, and a byte store places the byte on both lanes. All other accesses set both bits. `bus_sel` is 0 when `bus_stb` is low.
- R6: Load data is returned right-justified with all unused upper bits zero. A byte load returns the lane chosen by address bit 0.
- R7: `done` is high for exactly one core cycle, in the cycle right after the second cycle of the last beat. In that cycle `acc_cycles` equals twice the number of beats (2, 2, 4 or 8).
- R8: When `req_fetch` is 1, `req_size` and `req_we` are ignored. The sequencer performs a 32-bit read (two beats, `acc_cycles` = 4) with `bus_we` low, and returns the instruction in `rd_data[31:0]`.
- R9: While reset is applied and after it is released, the block is idle: `req_ready` is 1, and `bus_stb`, `bus_we`, `bus_sel` and `done` are 0. A reset during an access abandons that access without a `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Sequencer can take a request |
| req_fetch | input | 1 | Request is a 32-bit instruction fetch |
| req_we | input | 1 | Request is a store |
| req_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 64 | Store data, right-justified |
| done | output | 1 | One-cycle access completion pulse |
| rd_data | output | 64 | Load or fetch result, right-justified |
| acc_cycles | output | 4 | Core cycles the bus was occupied, valid with done |
| bus_addr | output | 31 | Half-word address of the current beat |
| bus_wdata | output | 16 | Store data for the current beat |
| bus_rdata | input | 16 | Read data returned by the bus |
| bus_stb | output | 1 | Beat in progress |
| bus_we | output | 1 | Beat is a write |
| bus_sel | output | 2 | Byte lane enables |

## Verification
A beat counter that is off by one shows at the ports at the first beat boundary. The bus address stops stepping by one, and `done` fires early or late compared with the 2/4/8-cycle cost the bench derives from the size code. A phase bit that has slipped breaks the two-cycle hold of the address and lane enables, and this is visible on the very next cycle. Wrong lane or slot steering leaves wrong bytes in the bench's bus memory right after a store. For loads, the error appears in `rd_data` during the single `done` cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Access size codes; the value is log2 of the byte count.
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bseq_ctrl.sv
// Beat sequencer: two core cycles per bus beat, beat index, cycle tally.
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int BEAT_W = 2,
  parameter int CYC_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BEAT_W-1:0] last_beat,
  output logic              idle,
  output logic              busy,
  output logic              phase,
  output logic              done,
  output logic              capture,
  output logic [BEAT_W-1:0] beat,
  output logic [CYC_W-1:0]  cycles
);

  seq_state_e state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase   <= 1'b0;
      beat    <= '0;
      cycles  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_BEAT;
            phase   <= 1'b0;
            beat    <= '0;
            cycles  <= '0;
          end
        end
        ST_BEAT: begin
          phase  <= ~phase;
          cycles <= cycles + CYC_W'(1);
          if (phase) begin
            if (beat == last_beat) begin
              state_q <= ST_DONE;
            end else begin
              beat <= beat + BEAT_W'(1);
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (state_q == ST_IDLE);
  assign busy    = (state_q == ST_BEAT);
  assign done    = (state_q == ST_DONE);
  assign capture = busy && phase;

endmodule

// File: rtl/bseq_lane.sv
// Byte-lane enables and store-data steering for the current beat.
module bseq_lane
  import bseq_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 64,
  parameter int BEAT_W = 2,
  parameter int LANES  = BUS_W / 8,
  parameter int LANE_W = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] offs,
  input  logic [BEAT_W-1:0] beat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              active,
  input  logic              we,
  output logic [LANES-1:0]  sel,
  output logic [BUS_W-1:0]  wbus
);

  int   bytes;
  int   align;
  logic narrow;

  always_comb begin
    bytes  = 1 << int'(size);
    narrow = (bytes < LANES);
    align  = int'(offs) & ~(bytes - 1);
    if (!active) begin
      sel = '0;
    end else if (narrow) begin
      sel = LANES'((1 << bytes) - 1) << align;
    end else begin
      sel = '1;
    end
  end

  // A narrow store repeats its bytes over every lane; a wide one takes the
  // slice of the store word that belongs to this beat.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int         bidx;
    logic [7:0] lb;
    always_comb begin
      if (narrow) bidx = l & (bytes - 1);
      else        bidx = int'(beat) * LANES + l;
      lb = (active && we) ? wdata[bidx*8 +: 8] : 8'h00;
    end
    assign wbus[l*8 +: 8] = lb;
  end

endmodule

// File: rtl/bseq_gather.sv
// Load-data assembly: one slot per beat, narrow loads right-justified.
module bseq_gather
  import bseq_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int DATA_W    = 64,
  parameter int MAX_BEATS = DATA_W / BUS_W,
  parameter int BEAT_W    = 2,
  parameter int LANES     = BUS_W / 8,
  parameter int LANE_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              capture,
  input  logic [BEAT_W-1:0] beat,
  input  acc_size_e         size,
  input  logic [LANE_W-1:0] offs,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [DATA_W-1:0] rd_data
);

  int               bytes;
  int               align;
  logic             narrow;
  logic [BUS_W-1:0] shifted;
  logic [BUS_W-1:0] nval;

  always_comb begin
    bytes   = 1 << int'(size);
    narrow  = (bytes < LANES);
    align   = int'(offs) & ~(bytes - 1);
    shifted = bus_rdata >> (align * 8);
    nval    = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < bytes) nval[k*8 +: 8] = shifted[k*8 +: 8];
    end
  end

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_slot
    logic [BUS_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        q <= '0;
      end else if (capture && (beat == BEAT_W'(g))) begin
        q <= (g == 0 && narrow) ? nval : bus_rdata;
      end
    end
    assign rd_data[g*BUS_W +: BUS_W] = q;
  end

endmodule

// File: rtl/bus_seq.sv
// Wide-to-narrow bus access sequencer top.
module bus_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16,
  parameter int INSN_W = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic                                 req_fetch,
  input  logic                                 req_we,
  input  logic [1:0]                           req_size,
  input  logic [ADDR_W-1:0]                    req_addr,
  input  logic [DATA_W-1:0]                    req_wdata,
  output logic                                 done,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [$clog2(2*DATA_W/BUS_W):0]      acc_cycles,
  output logic [ADDR_W-$clog2(BUS_W/8)-1:0]    bus_addr,
  output logic [BUS_W-1:0]                     bus_wdata,
  input  logic [BUS_W-1:0]                     bus_rdata,
  output logic                                 bus_stb,
  output logic                                 bus_we,
  output logic [BUS_W/8-1:0]                   bus_sel
);

  localparam int LANES     = BUS_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int MAX_BEATS = DATA_W / BUS_W;
  localparam int BEAT_W    = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int CYC_W     = $clog2(2 * MAX_BEATS) + 1;
  localparam int BADDR_W   = ADDR_W - LANE_W;
  localparam acc_size_e FETCH_SZ = acc_size_e'($clog2(INSN_W / 8));

  logic [ADDR_W-1:0] addr_q;
  acc_size_e         size_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;

  logic              idle, busy, seq_phase, capture, start;
  logic [BEAT_W-1:0] beat, last_beat;
  int                bytes_q;
  int                beats_q;

  assign start     = req_valid && idle;
  assign req_ready = idle;

  // Request capture; a fetch overrides size and write flag.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (start) begin
      addr_q  <= req_addr;
      size_q  <= req_fetch ? FETCH_SZ : acc_size_e'(req_size);
      we_q    <= req_we && !req_fetch;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    bytes_q   = 1 << int'(size_q);
    beats_q   = (bytes_q * 8 <= BUS_W) ? 1 : (bytes_q * 8) / BUS_W;
    last_beat = BEAT_W'(beats_q - 1);
  end

  bseq_ctrl #(
    .BEAT_W (BEAT_W),
    .CYC_W  (CYC_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .last_beat (last_beat),
    .idle      (idle),
    .busy      (busy),
    .phase     (seq_phase),
    .done      (done),
    .capture   (capture),
    .beat      (beat),
    .cycles    (acc_cycles)
  );

  bseq_lane #(
    .BUS_W  (BUS_W),
    .DATA_W (DATA_W),
    .BEAT_W (BEAT_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lane (
    .size   (size_q),
    .offs   (addr_q[LANE_W-1:0]),
    .beat   (beat),
    .wdata  (wdata_q),
    .active (busy),
    .we     (we_q),
    .sel    (bus_sel),
    .wbus   (bus_wdata)
  );

  bseq_gather #(
    .BUS_W     (BUS_W),
    .DATA_W    (DATA_W),
    .MAX_BEATS (MAX_BEATS),
    .BEAT_W    (BEAT_W),
    .LANES     (LANES),
    .LANE_W    (LANE_W)
  ) u_gather (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start),
    .capture   (capture && !we_q),
    .beat      (beat),
    .size      (size_q),
    .offs      (addr_q[LANE_W-1:0]),
    .bus_rdata (bus_rdata),
    .rd_data   (rd_data)
  );

  assign bus_stb  = busy;
  assign bus_we   = busy && we_q;
  assign bus_addr = busy ? (addr_q[ADDR_W-1:LANE_W] + BADDR_W'(beat)) : '0;

endmodule

// File: rtl/bus_seq_chk.sv
// Protocol checker bound to the sequencer top.
module bus_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int BUS_W  = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              req_ready,
  input logic                              done,
  input logic                              bus_stb,
  input logic [BUS_W/8-1:0]                bus_sel,
  input logic [ADDR_W-$clog2(BUS_W/8)-1:0] bus_addr,
  input logic [BUS_W-1:0]                  bus_wdata,
  input logic [$clog2(2*DATA_W/BUS_W):0]   acc_cycles,
  input logic                              seq_phase
);

  a_r1_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb || done) |-> !req_ready);

  a_r3_beat_starts_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_stb) |-> !seq_phase);

  a_r3_beat_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && !seq_phase) |=> (bus_stb && $stable(bus_addr) && $stable(bus_sel)
                                 && $stable(bus_wdata)));

  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && seq_phase) |=> (!bus_stb || (bus_addr == $past(bus_addr) + 1'b1)));

  a_r5_sel_active: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb |-> (bus_sel != '0));

  a_r5_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_stb |-> (bus_sel == '0));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_stb) && $past(seq_phase) && !bus_stb));

  a_r7_cycles_even: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!acc_cycles[0] && acc_cycles != '0));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_stb && !done));

endmodule

bind bus_seq bus_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BUS_W  (BUS_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .bus_stb    (bus_stb),
  .bus_sel    (bus_sel),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .acc_cycles (acc_cycles),
  .seq_phase  (seq_phase)
);

// File: tb/sim_bus_seq.sv
module sim_bus_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_fetch = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        done;
  logic [63:0] rd_data;
  logic [3:0]  acc_cycles;
  logic [30:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        bus_stb;
  logic        bus_we;
  logic [1:0]  bus_sel;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bus_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_fetch(req_fetch), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .acc_cycles(acc_cycles), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_stb(bus_stb), .bus_we(bus_we), .bus_sel(bus_sel)
  );

  // Bus-side memory model: 64 half-words, byte-lane writes.
  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  logic [15:0] mem [64];
  logic [7:0]  shadow [128];

  assign bus_rdata = mem[bus_addr[5:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= {init_byte(2*i+1), init_byte(2*i)};
    end else if (bus_stb && bus_we) begin
      if (bus_sel[0]) mem[bus_addr[5:0]][7:0]  <= bus_wdata[7:0];
      if (bus_sel[1]) mem[bus_addr[5:0]][15:8] <= bus_wdata[15:8];
    end
  end

  task automatic init_shadow();
    for (int i = 0; i < 128; i++) shadow[i] = init_byte(i);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic bit mem_matches();
    for (int i = 0; i < 64; i++)
      if (mem[i] !== {shadow[2*i+1], shadow[2*i]}) return 1'b0;
    return 1'b1;
  endfunction

  typedef struct packed {
    logic        fetch;
    logic        we;
    logic [1:0]  size;
    logic [7:0]  addr;
    logic [63:0] wdata;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 1'b0, 2'd0, 8'h11, 64'h0},
    '{1'b0, 1'b0, 2'd1, 8'h20, 64'h0},
    '{1'b0, 1'b0, 2'd2, 8'h24, 64'h0},
    '{1'b0, 1'b0, 2'd3, 8'h30, 64'h0},
    '{1'b1, 1'b1, 2'd3, 8'h40, 64'hDEADBEEF_CAFEF00D},
    '{1'b0, 1'b1, 2'd0, 8'h13, 64'h0000_0000_0000_00EF},
    '{1'b0, 1'b0, 2'd1, 8'h12, 64'h0},
    '{1'b0, 1'b1, 2'd3, 8'h50, 64'h11223344_55667788},
    '{1'b0, 1'b0, 2'd3, 8'h50, 64'h0},
    '{1'b0, 1'b1, 2'd2, 8'h60, 64'hFFFFFFFF_A5C3E1F0},
    '{1'b0, 1'b0, 2'd2, 8'h60, 64'h0},
    '{1'b0, 1'b1, 2'd1, 8'h6A, 64'h0000_0000_0000_BEEF},
    '{1'b0, 1'b0, 2'd3, 8'h68, 64'h0},
    '{1'b0, 1'b1, 2'd0, 8'h70, 64'h0000_0000_0000_005A},
    '{1'b0, 1'b0, 2'd0, 8'h70, 64'h0},
    '{1'b0, 1'b0, 2'd0, 8'h71, 64'h0}
  };

  task automatic run_vec(input vec_t v);
    int          bytes, beats, n, a;
    bit          wr;
    logic [63:0] exp;
    logic [15:0] ew;
    logic [1:0]  es;
    a     = int'(v.addr);
    bytes = v.fetch ? 4 : (1 << int'(v.size));
    beats = (bytes <= 2) ? 1 : bytes / 2;
    wr    = v.we && !v.fetch;
    es    = (bytes == 1) ? (a[0] ? 2'b10 : 2'b01) : 2'b11;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_fetch = v.fetch; req_we = v.we; req_size = v.size;
    req_addr = 32'(a); req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      if (bus_stb) begin
        chk(bus_addr === 31'(a/2 + n/2), "R4 beat address", 64'(bus_addr), 64'(a/2 + n/2));
        chk(bus_sel === es, "R5 lane enables", 64'(bus_sel), 64'(es));
        chk(bus_we === wr, "R8 write strobe", 64'(bus_we), 64'(wr));
        chk(req_ready === 1'b0, "R1 not ready while busy", 64'(req_ready), 64'd0);
        if (wr) begin
          ew = (bytes == 1) ? {v.wdata[7:0], v.wdata[7:0]} : v.wdata[16*(n/2) +: 16];
          chk(bus_wdata === ew, "R4 R5 store beat data", 64'(bus_wdata), 64'(ew));
        end
      end
      n++;
      @(negedge clk);
    end
    chk(n == 2*beats, "R3 R2 bus cycles before done", 64'(n), 64'(2*beats));
    chk(acc_cycles === 4'(2*beats), "R7 cycle report", 64'(acc_cycles), 64'(2*beats));
    if (!wr) begin
      exp = '0;
      for (int k = 0; k < bytes; k++) exp |= 64'(shadow[a+k]) << (8*k);
      chk(rd_data === exp, v.fetch ? "R8 fetch data" : "R6 load data", rd_data, exp);
    end
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
    if (wr) for (int k = 0; k < bytes; k++) shadow[a+k] = v.wdata[8*k +: 8];
    chk(mem_matches(), v.fetch ? "R8 fetch writes nothing" : "R5 memory contents",
        64'(mem_matches()), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] exp;
    init_shadow();
    repeat (3) @(negedge clk);
    // R9: state during and after reset
    chk(req_ready === 1'b1 && bus_stb === 1'b0 && done === 1'b0,
        "R9 idle in reset", {61'd0, req_ready, bus_stb, done}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_stb === 1'b0 && bus_sel === 2'b00 && bus_we === 1'b0,
        "R9 idle after reset", {60'd0, req_ready, bus_stb, bus_sel}, 64'd8);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // R1: a request offered while busy is ignored.
    @(negedge clk);
    req_valid = 1'b1; req_fetch = 1'b0; req_we = 1'b0; req_size = 2'd3;
    req_addr = 32'h30; req_wdata = '0;
    @(negedge clk);
    req_we = 1'b1; req_size = 2'd0; req_addr = 32'h78; req_wdata = 64'hFF;
    for (int c = 0; c < 4; c++) begin
      chk(req_ready === 1'b0, "R1 back-pressure", 64'(req_ready), 64'd0);
      @(negedge clk);
    end
    req_valid = 1'b0; req_we = 1'b0;
    while (!done) @(negedge clk);
    exp = '0;
    for (int k = 0; k < 8; k++) exp |= 64'(shadow[8'h30 + k]) << (8*k);
    chk(rd_data === exp, "R1 held request intact", rd_data, exp);
    @(negedge clk);
    @(negedge clk);
    chk(bus_stb === 1'b0 && mem_matches(), "R1 ignored request left memory",
        64'(mem_matches()), 64'd1);

    // R9: reset in the middle of an access abandons it.
    req_valid = 1'b1; req_we = 1'b1; req_size = 2'd3; req_addr = 32'h40;
    req_wdata = 64'h0102030405060708;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(bus_stb === 1'b0 && done === 1'b0, "R9 reset aborts access",
        {62'd0, bus_stb, done}, 64'd0);
    rst_n = 1'b1;
    init_shadow();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      chk(done === 1'b0 && bus_stb === 1'b0 && req_ready === 1'b1,
          "R9 no done after abort", {61'd0, done, bus_stb, req_ready}, 64'd1);
    end
    chk(mem_matches(), "R9 memory after abort", 64'(mem_matches()), 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule